// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Cache Lookup

This block is the lookup half of a first-level data cache whose set index and line offset lie wholly inside the page offset. Those bits are the same before and after address translation. A request carries only the page-offset part of the virtual address. In the cycle the request is accepted, the block latches every way of the selected set: the stored physical page numbers, their valid bits and the full lines. The translation unit works in parallel. When it presents a valid physical page number in a later cycle, the held tags are compared against that page number. The block then reports hit or miss together with the addressed 64-bit word.

Lines are installed through a separate fill port. A fill writes a complete line and its physical page number into one way of a set, chosen by a per-set round-robin pointer, and marks that way valid. Elaboration stops if the configured index and line-offset widths together exceed the page-offset width. In that case the set could not be chosen before translation.

Top module: `vipt_cache`

## Requirements
- R1: After reset no way of any set is valid, `reqReady` is 1 and `respValid` is 0. A lookup made before any fill misses.
- R2: The set index is `reqVaOffset[11:6]`. The word within the 64-byte line is `reqVaOffset[5:3]`, and word k occupies bits [64k+63:64k] of the line. Bits [2:0] are ignored.
- R3: A lookup is accepted in a cycle where `reqValid` and `reqReady` are both 1. Its result appears combinationally, with `respValid` high, in the first later cycle in which `xlatValid` is 1. No response appears in any other cycle.
- R4: A hit occurs when a valid way of the held set stores a page number equal to `xlatPpn`. `respHit` is then 1 and `respWord` is the selected word of that way's line.
- R5: On a miss, `respHit` is 0 and `respWord` is all zeros. `respHit` is never 1 without `respValid`.
- R6: While a lookup is held and `xlatValid` is 0, `reqReady` is 0 and no response is given. The value on `xlatPpn` during those cycles has no effect on the result.
- R7: A fill writes `fillLine` and `fillPpn` into the way that the set's round-robin pointer selects, sets that way valid, and advances the pointer modulo 8. The ninth fill into a set replaces the first.
- R8: A fill in the same cycle that a lookup of the same set is accepted is not seen by that lookup. It is seen by lookups accepted afterwards.
- R9: In a cycle where a response is given, `reqReady` is 1, so a new lookup can be accepted in that same cycle.
- R10: Each set has its own round-robin pointer and ways. Fills to one set do not disturb the lines of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request present |
| reqReady | output | 1 | Lookup can be accepted this cycle |
| reqVaOffset | input | 12 | Page-offset bits of the virtual address |
| xlatValid | input | 1 | Translation result present |
| xlatPpn | input | 40 | Physical page number from translation |
| fillValid | input | 1 | Line fill present |
| fillIdx | input | 6 | Set receiving the fill |
| fillPpn | input | 40 | Physical page number stored as the tag |
| fillLine | input | 512 | Full line data, word 0 in the low bits |
| respValid | output | 1 | Lookup result present |
| respHit | output | 1 | Lookup hit |
| respWord | output | 64 | Selected word on a hit, zero on a miss |

## Verification
Two functions can fall in the same cycle: a line fill and the acceptance of a lookup into the same set. They can also overlap with the response to an earlier lookup. The bench drives a fill and a request to one set on the same edge and expects a miss, because the held copy predates the write. A second lookup to that set must then hit. Separately, the bench drives a response and a new request in one cycle and expects both results in order, with `reqReady` high in the overlap cycle.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic captureSet;  // latch the indexed set into the hold registers
    logic fillWrite;   // install the fill line in the round-robin way
    logic respond;     // held lookup meets its translation this cycle
  } ctrl_strobe_t;
endpackage

// File: rtl/vipt_ctrl.sv
`timescale 1ns/1ps
module vipt_ctrl
  import vipt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         xlatValid,
  input  logic         fillValid,
  output logic         reqReady,
  output ctrl_strobe_t strb
);
  logic busy;

  assign reqReady = !busy || xlatValid;

  always_comb begin
    strb.captureSet = reqValid && reqReady;
    strb.fillWrite  = fillValid;
    strb.respond    = busy && xlatValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                busy <= 1'b0;
    else if (strb.captureSet) busy <= 1'b1;
    else if (strb.respond)    busy <= 1'b0;
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xlatValid) |=> busy);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && xlatValid && !reqValid) |=> !busy);
endmodule

// File: rtl/vipt_datapath.sv
`timescale 1ns/1ps
module vipt_datapath
  import vipt_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 6,
  parameter int WAYS   = 8,
  parameter int PPN_W  = 40,
  parameter int WORD_W = 64,
  localparam int SETS   = 2 ** IDX_W,
  localparam int LINE_W = (2 ** OFF_W) * 8,
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [IDX_W-1:0]   reqIdx,
  input  logic [WSEL_W-1:0]  reqWordSel,
  input  logic [PPN_W-1:0]   xlatPpn,
  input  logic [IDX_W-1:0]   fillIdx,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic [LINE_W-1:0]  fillLine,
  output logic               respHit,
  output logic [WORD_W-1:0]  respWord
);
  logic [PPN_W-1:0]  tagArr  [SETS][WAYS];
  logic [LINE_W-1:0] lineArr [SETS][WAYS];
  logic [WAYS-1:0]   validArr [SETS];
  logic [WAY_W-1:0]  rrPtr    [SETS];

  logic [PPN_W-1:0]  rdTag  [WAYS];
  logic [LINE_W-1:0] rdLine [WAYS];
  logic [WAYS-1:0]   rdValid;
  logic [WSEL_W-1:0] rdWordSel;

  logic [WAYS-1:0]   hitVec;
  logic [WORD_W-1:0] wordOf [WAYS];

  // Valid bits and replacement pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validArr[s] <= '0;
        rrPtr[s]    <= '0;
      end
    end else if (strb.fillWrite) begin
      validArr[fillIdx][rrPtr[fillIdx]] <= 1'b1;
      rrPtr[fillIdx] <= rrPtr[fillIdx] + 1'b1;
    end
  end

  // Tag and line storage
  always_ff @(posedge clk) begin
    if (strb.fillWrite) begin
      tagArr[fillIdx][rrPtr[fillIdx]]  <= fillPpn;
      lineArr[fillIdx][rrPtr[fillIdx]] <= fillLine;
    end
  end

  // Set read with untranslated index, held until the translation arrives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= '0;
    end else if (strb.captureSet) begin
      rdValid <= validArr[reqIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.captureSet) begin
      for (int w = 0; w < WAYS; w++) begin
        rdTag[w]  <= tagArr[reqIdx][w];
        rdLine[w] <= lineArr[reqIdx][w];
      end
      rdWordSel <= reqWordSel;
    end
  end

  // Physical tag compare per way
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hitVec[w] = rdValid[w] && (rdTag[w] == xlatPpn);
    assign wordOf[w] = rdLine[w][rdWordSel*WORD_W +: WORD_W];
  end

  always_comb begin
    logic [WORD_W-1:0] acc;
    acc = '0;
    for (int w = 0; w < WAYS; w++) acc |= wordOf[w] & {WORD_W{hitVec[w]}};
    respHit  = strb.respond && (|hitVec);
    respWord = strb.respond ? acc : '0;
  end

  // R2
  held_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureSet |=> $stable(rdWordSel));

  // R7
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillWrite |=> (validArr[$past(fillIdx)] != '0));
endmodule

// File: rtl/vipt_cache.sv
`timescale 1ns/1ps
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int PAGE_OFF_W = 12,
  parameter int IDX_W      = 6,
  parameter int OFF_W      = 6,
  parameter int WAYS       = 8,
  parameter int PPN_W      = 40,
  parameter int WORD_W     = 64,
  localparam int LINE_W     = (2 ** OFF_W) * 8,
  localparam int WORDS      = LINE_W / WORD_W,
  localparam int WSEL_W     = $clog2(WORDS),
  localparam int BYTE_SEL_W = $clog2(WORD_W / 8)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic [PAGE_OFF_W-1:0] reqVaOffset,
  input  logic                  xlatValid,
  input  logic [PPN_W-1:0]      xlatPpn,
  input  logic                  fillValid,
  input  logic [IDX_W-1:0]      fillIdx,
  input  logic [PPN_W-1:0]      fillPpn,
  input  logic [LINE_W-1:0]     fillLine,
  output logic                  respValid,
  output logic                  respHit,
  output logic [WORD_W-1:0]     respWord
);
  if (IDX_W + OFF_W > PAGE_OFF_W) begin : g_bad_index
    $fatal(1, "index and line offset must fit inside the page offset");
  end
  if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
    $fatal(1, "way count must be a power of two of at least 2");
  end

  ctrl_strobe_t strb;
  logic [IDX_W-1:0]  reqIdx;
  logic [WSEL_W-1:0] reqWordSel;
  logic              unusedByteBits;

  assign reqIdx         = reqVaOffset[OFF_W +: IDX_W];
  assign reqWordSel     = reqVaOffset[BYTE_SEL_W +: WSEL_W];
  assign unusedByteBits = ^reqVaOffset[BYTE_SEL_W-1:0];
  assign respValid      = strb.respond;

  vipt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .xlatValid (xlatValid),
    .fillValid (fillValid),
    .reqReady  (reqReady),
    .strb      (strb)
  );

  vipt_datapath #(
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .WAYS   (WAYS),
    .PPN_W  (PPN_W),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqIdx     (reqIdx),
    .reqWordSel (reqWordSel),
    .xlatPpn    (xlatPpn),
    .fillIdx    (fillIdx),
    .fillPpn    (fillPpn),
    .fillLine   (fillLine),
    .respHit    (respHit),
    .respWord   (respWord)
  );

  // R5
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> respValid);

  // R5
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (respWord == '0));
endmodule

// File: tb/vipt_cache_test.sv
`timescale 1ns/1ps
module vipt_cache_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [11:0]  reqVaOffset = '0;
  logic         xlatValid = 1'b0;
  logic [39:0]  xlatPpn = '0;
  logic         fillValid = 1'b0;
  logic [5:0]   fillIdx = '0;
  logic [39:0]  fillPpn = '0;
  logic [511:0] fillLine = '0;
  logic         respValid;
  logic         respHit;
  logic [63:0]  respWord;

  always #5 clk = ~clk;

  vipt_cache uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaOffset(reqVaOffset), .xlatValid(xlatValid), .xlatPpn(xlatPpn),
    .fillValid(fillValid), .fillIdx(fillIdx), .fillPpn(fillPpn),
    .fillLine(fillLine), .respValid(respValid), .respHit(respHit),
    .respWord(respWord)
  );

  int nCompared = 0;
  int nMismatch = 0;
  bit finished  = 0;

  // Reference model built from the requirements
  logic [39:0] mTag [64][8];
  bit          mVal [64][8];
  int          mPtr [64];

  logic        expHitQ [$];
  logic [63:0] expWordQ [$];
  string       tagQ [$];

  function automatic logic [63:0] wordFor(logic [39:0] ppn, int set, int k);
    return {ppn[31:0], 8'(set), 8'(k), 16'hC0DE};
  endfunction

  function automatic logic [511:0] lineFor(logic [39:0] ppn, int set);
    logic [511:0] l;
    for (int k = 0; k < 8; k++) l[k*64 +: 64] = wordFor(ppn, set, k);
    return l;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelLookup(int set, int k, logic [39:0] ppn,
                             output logic eh, output logic [63:0] ew);
    eh = 1'b0; ew = '0;
    for (int w = 0; w < 8; w++)
      if (mVal[set][w] && mTag[set][w] == ppn) begin
        eh = 1'b1; ew = wordFor(ppn, set, k);
      end
  endtask

  task automatic modelFill(int set, logic [39:0] ppn);
    mTag[set][mPtr[set]] = ppn;
    mVal[set][mPtr[set]] = 1'b1;
    mPtr[set] = (mPtr[set] + 1) % 8;
  endtask

  task automatic driveFill(int set, logic [39:0] ppn);
    fillValid = 1'b1; fillIdx = 6'(set); fillPpn = ppn;
    fillLine = lineFor(ppn, set);
  endtask

  task automatic doFill(int set, logic [39:0] ppn);
    @(negedge clk);
    driveFill(set, ppn);
    modelFill(set, ppn);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  // Low byte bits set to 5: they must be ignored (R2)
  function automatic logic [11:0] mkVa(int set, int k);
    return {6'(set), 3'(k), 3'b101};
  endfunction

  task automatic pushExp(logic eh, logic [63:0] ew, string tag);
    expHitQ.push_back(eh); expWordQ.push_back(ew); tagQ.push_back(tag);
  endtask

  task automatic doLookup(int set, int k, logic [39:0] ppn, int stallCyc, string tag);
    logic eh; logic [63:0] ew;
    @(negedge clk);
    reqValid = 1'b1; reqVaOffset = mkVa(set, k); xlatValid = 1'b0;
    modelLookup(set, k, ppn, eh, ew);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < stallCyc; i++) begin
      xlatPpn = ~ppn;  // ignored while not valid (R6)
      #1 check(reqReady == 1'b0, "R6 reqReady during stall", 64'(reqReady), 64'd0);
      @(negedge clk);
    end
    pushExp(eh, ew, tag);
    xlatValid = 1'b1; xlatPpn = ppn;
    @(negedge clk);
    xlatValid = 1'b0;
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && respValid) begin
        if (expHitQ.size() == 0) begin
          check(1'b0, "R3 response without pending lookup", 64'(respValid), 64'd0);
        end else begin
          logic eh; logic [63:0] ew; string tg;
          eh = expHitQ.pop_front(); ew = expWordQ.pop_front(); tg = tagQ.pop_front();
          check(respHit == eh, {tg, " hit"}, 64'(respHit), 64'(eh));
          check(respWord == ew, {tg, " word"}, respWord, ew);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 64; s++) begin
      mPtr[s] = 0;
      for (int w = 0; w < 8; w++) begin mVal[s][w] = 1'b0; mTag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(reqReady == 1'b1, "R1 reqReady after reset", 64'(reqReady), 64'd1);
    check(respValid == 1'b0, "R1 respValid after reset", 64'(respValid), 64'd0);

    // R1: empty cache misses
    doLookup(5, 2, 40'h00_1234_5678, 0, "R1 lookup before fill");

    // R4 / R2: hit on several words, R5: wrong page misses
    doFill(5, 40'hAB_CDEF_0011);
    doLookup(5, 3, 40'hAB_CDEF_0011, 0, "R4 hit word 3");
    doLookup(5, 0, 40'hAB_CDEF_0011, 0, "R2 word 0");
    doLookup(5, 7, 40'hAB_CDEF_0011, 0, "R2 word 7");
    doLookup(5, 1, 40'hAB_CDEF_0012, 0, "R5 tag mismatch miss");
    doLookup(6, 1, 40'hAB_CDEF_0011, 0, "R5 other set miss");

    // R6: stalled translation, then hit
    doLookup(5, 4, 40'hAB_CDEF_0011, 3, "R6 stalled hit");
    doLookup(5, 4, 40'hAB_CDEF_0099, 2, "R6 stalled miss");

    // R7: nine fills into one set, first is evicted
    for (int i = 0; i < 9; i++) doFill(9, 40'(100 + i));
    doLookup(9, 0, 40'd100, 0, "R7 evicted by ninth fill");
    doLookup(9, 5, 40'd101, 0, "R7 second fill kept");
    doLookup(9, 6, 40'd108, 0, "R7 ninth fill present");

    // R10: set 5 untouched by set 9 fills
    doLookup(5, 6, 40'hAB_CDEF_0011, 0, "R10 independent set");

    // R8: fill and lookup of the same set on the same edge
    begin
      logic eh; logic [63:0] ew;
      @(negedge clk);
      reqValid = 1'b1; reqVaOffset = mkVa(20, 2);
      modelLookup(20, 2, 40'h77_0000_0001, eh, ew);
      driveFill(20, 40'h77_0000_0001);
      modelFill(20, 40'h77_0000_0001);
      @(negedge clk);
      reqValid = 1'b0; fillValid = 1'b0;
      pushExp(eh, ew, "R8 same-cycle fill not seen");
      xlatValid = 1'b1; xlatPpn = 40'h77_0000_0001;
      @(negedge clk);
      xlatValid = 1'b0;
    end
    doLookup(20, 2, 40'h77_0000_0001, 0, "R8 later lookup sees fill");

    // R9: response and new acceptance in the same cycle
    begin
      logic ehA, ehB; logic [63:0] ewA, ewB;
      @(negedge clk);
      reqValid = 1'b1; reqVaOffset = mkVa(9, 1);
      modelLookup(9, 1, 40'd103, ehA, ewA);
      @(negedge clk);
      pushExp(ehA, ewA, "R9 first of pair");
      xlatValid = 1'b1; xlatPpn = 40'd103;
      reqValid = 1'b1; reqVaOffset = mkVa(5, 5);
      modelLookup(5, 5, 40'hAB_CDEF_0011, ehB, ewB);
      #1 check(reqReady == 1'b1, "R9 reqReady while responding", 64'(reqReady), 64'd1);
      @(negedge clk);
      reqValid = 1'b0;
      pushExp(ehB, ewB, "R9 second of pair");
      xlatPpn = 40'hAB_CDEF_0011;
      @(negedge clk);
      xlatValid = 1'b0;
    end

    repeat (4) @(negedge clk);
    #3;
    check(expHitQ.size() == 0, "R3 all responses delivered", 64'(expHitQ.size()), 64'd0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule